// File: doc/BRIEF.md
# SPI Sticky Status Flag Register

This block is the status and interrupt register of an SPI controller. It runs on the peripheral clock. The SPI core sends it single-cycle event pulses for chip-select fall, rise and error, receive overflow, receive byte-count done, transmit byte-count done and transmit underflow. The block also watches the ready pin and the MISO line itself for the flow-control ready edge. Each event is caught in a sticky flag. Software reads the flags through a simple register port and clears them by writing 1 to them.

A read-only bit gives the chip-select level after synchronisation into the peripheral clock. The flags are gated by interrupt-enable and mask inputs and merged into one registered interrupt line. Some flags are forced clear while the controller enable is low.

Each flag is a two-state machine. `FLAG_CLEAR` goes to `FLAG_HELD` on *catch*, which is a set event while not killed. `FLAG_HELD` goes back to `FLAG_CLEAR` on *drop*, which is either a kill, or a write-1 with no set event in the same cycle. In every other case the flag stays in its current state.

Top module: `spi_stat_reg`

## Requirements
- R1: During and right after reset, `reg_rdata` reads 0x0800: bit 11 (chip-select level) is 1 and every other bit is 0. `irq` is 0.
- R2: An event pulse sets its flag on the next clock edge, and the flag then holds until it is cleared. Flag bit positions are: 15 ready edge, 14 CS fall, 13 CS rise, 12 CS error, 7 RX overflow, 6 RX done, 5 TX done, 4 TX underflow.
- R3: A register write with a 1 at a flag position clears that flag. A 0 leaves it unchanged. If a set event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R4: Bit 11 shows `cs_n_raw` delayed by SYNC_STAGES clock edges. Writes have no effect on bit 11 or on the reserved bits 10:8 and 3:0, which always read 0.
- R5: While `ctl_en` is 0, the CS rise, RX overflow, RX done, TX done and TX underflow flags are held at 0, even if their events occur. The CS fall, CS error and ready-edge flags are not affected by `ctl_en`.
- R6: The ready-edge flag sets only when `flow_mode[1]` is 1. Mode 2'b10 watches `rdy_pin` and mode 2'b11 watches `miso_pin`. `flow_rise`=1 selects the rising edge and 0 selects the falling edge. An edge is a change between the value sampled at the previous clock edge and the current value. In modes 2'b00 and 2'b01 the flag never sets.
- R7: The RX done flag sets on `ev_rx_done` only while `ctl_tim` is 0. The TX done flag sets on `ev_tx_done` only while `ctl_tim` is 1.
- R8: `irq` is registered and goes high one cycle after any of these conditions holds:
  - ready flag with `ie_rdy`
  - CS fall or CS rise flag with `ie_cs`
  - CS error flag (this one has no enable)
  - RX done or TX done flag
  - RX overflow with `ie_rxovf` and not `ctl_rxovf_mask`
  - TX underflow with `ie_txudf` and not `ctl_txudf_mask`

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Write data; a 1 clears the matching flag |
| reg_rdata | output | 16 | Status register contents |
| cs_n_raw | input | 1 | Chip-select line, asynchronous |
| ev_cs_fall | input | 1 | Chip-select falling-edge event |
| ev_cs_rise | input | 1 | Chip-select rising-edge event |
| ev_cs_err | input | 1 | Chip-select dropped mid-byte |
| ev_rx_ovf | input | 1 | Receive FIFO overflow event |
| ev_rx_done | input | 1 | Receive byte count reached |
| ev_tx_done | input | 1 | Transmit byte count reached |
| ev_tx_udf | input | 1 | Transmit FIFO underflow event |
| rdy_pin | input | 1 | Ready flow-control pin level |
| miso_pin | input | 1 | MISO line level |
| flow_mode | input | 2 | Flow-control mode |
| flow_rise | input | 1 | 1: rising ready edge, 0: falling |
| ctl_en | input | 1 | Controller enable |
| ctl_tim | input | 1 | Transfer-initiate mode: 1 on transmit, 0 on receive |
| ctl_rxovf_mask | input | 1 | Suppress RX overflow interrupt |
| ctl_txudf_mask | input | 1 | Suppress TX underflow interrupt |
| ie_rdy | input | 1 | Ready-edge interrupt enable |
| ie_cs | input | 1 | CS fall/rise interrupt enable |
| ie_rxovf | input | 1 | RX overflow interrupt enable |
| ie_txudf | input | 1 | TX underflow interrupt enable |
| irq | output | 1 | Combined registered interrupt |

## Verification
The bench builds the block with SYNC_STAGES set to 3 instead of the default 2. This way the chip-select level check covers a synchroniser deeper than the default, and an off-by-one in the delay shows up as a mismatch. The random run covers all four flow-control modes and both edge polarities. It also toggles the enable, mask and transfer-mode inputs, so the kill, gating and set-wins paths are all exercised while flags are set.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

    localparam int REG_W  = 16;
    localparam int NFLAG  = 8;
    localparam int CS_POS = 11;

    // Flag indices, in the order used by the flag vector
    localparam int F_TXUDF  = 0;
    localparam int F_TXDONE = 1;
    localparam int F_RXDONE = 2;
    localparam int F_RXOVF  = 3;
    localparam int F_CSERR  = 4;
    localparam int F_CSRISE = 5;
    localparam int F_CSFALL = 6;
    localparam int F_RDY    = 7;

    // Bit position of each flag in the status word
    localparam int FLAG_POS [NFLAG] = '{4, 5, 6, 7, 12, 13, 14, 15};

    // Flags that are forced clear while the controller is disabled
    localparam logic [NFLAG-1:0] EN_KILL_MASK = 8'b0010_1111;

    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_HELD  = 1'b1
    } flag_state_e;

endpackage

// File: rtl/spi_stat_flag.sv
module spi_stat_flag
    import spi_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic kill_i,
    output logic q_o
);

    flag_state_e state_q;
    flag_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: if (!kill_i && set_i)             state_d = FLAG_HELD;
            FLAG_HELD:  if (kill_i || (clr_i && !set_i))  state_d = FLAG_CLEAR;
        endcase
    end

    always_comb begin
        q_o = (state_q == FLAG_HELD);
    end

    // An unkilled event leaves the flag set, even against a clear
    assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !kill_i) |=> q_o);

    // A clearing write with no event removes the flag
    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);

    // Kill holds the flag low
    assert_kill_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        kill_i |=> !q_o);

    // With no stimulus a set flag stays set
    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o && !clr_i && !kill_i) |=> q_o);

endmodule

// File: rtl/spi_stat_cs_sync.sv
module spi_stat_cs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    output logic cs_lvl_o
);

    localparam int LAST = STAGES - 1;

    logic [LAST:0] pipe_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= '1;
                else        pipe_q <= cs_n_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= '1;
                else        pipe_q <= {pipe_q[LAST-1:0], cs_n_i};
            end
        end
    endgenerate

    assign cs_lvl_o = pipe_q[LAST];

endmodule

// File: rtl/spi_stat_rdy_edge.sv
module spi_stat_rdy_edge (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rdy_pin_i,
    input  logic       miso_pin_i,
    input  logic [1:0] mode_i,
    input  logic       rise_i,
    output logic       edge_o
);

    logic rdy_prev_q;
    logic miso_prev_q;
    logic line_now;
    logic line_prev;

    // Both lines are tracked always, so switching modes never creates a false edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_prev_q  <= 1'b0;
            miso_prev_q <= 1'b0;
        end else begin
            rdy_prev_q  <= rdy_pin_i;
            miso_prev_q <= miso_pin_i;
        end
    end

    always_comb begin
        line_now  = mode_i[0] ? miso_pin_i  : rdy_pin_i;
        line_prev = mode_i[0] ? miso_prev_q : rdy_prev_q;
        if (!mode_i[1])  edge_o = 1'b0;
        else if (rise_i) edge_o = line_now & ~line_prev;
        else             edge_o = ~line_now & line_prev;
    end

    assert_no_edge_idle_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i[1] |-> !edge_o);

endmodule

// File: rtl/spi_stat_irq_merge.sv
module spi_stat_irq_merge
    import spi_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] flags_i,
    input  logic             ie_rdy_i,
    input  logic             ie_cs_i,
    input  logic             ie_rxovf_i,
    input  logic             ie_txudf_i,
    input  logic             rxovf_mask_i,
    input  logic             txudf_mask_i,
    output logic             irq_o
);

    logic [NFLAG-1:0] gated;
    logic             irq_q;

    always_comb begin
        gated           = '0;
        gated[F_RDY]    = flags_i[F_RDY]    & ie_rdy_i;
        gated[F_CSFALL] = flags_i[F_CSFALL] & ie_cs_i;
        gated[F_CSRISE] = flags_i[F_CSRISE] & ie_cs_i;
        gated[F_CSERR]  = flags_i[F_CSERR];
        gated[F_RXOVF]  = flags_i[F_RXOVF]  & ie_rxovf_i & ~rxovf_mask_i;
        gated[F_RXDONE] = flags_i[F_RXDONE];
        gated[F_TXDONE] = flags_i[F_TXDONE];
        gated[F_TXUDF]  = flags_i[F_TXUDF]  & ie_txudf_i & ~txudf_mask_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |gated;
    end

    assign irq_o = irq_q;

    assert_cserr_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flags_i[F_CSERR] |=> irq_o);

    assert_quiet_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_i == '0) |=> !irq_o);

endmodule

// File: rtl/spi_stat_reg.sv
module spi_stat_reg
    import spi_stat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             cs_n_raw,
    input  logic             ev_cs_fall,
    input  logic             ev_cs_rise,
    input  logic             ev_cs_err,
    input  logic             ev_rx_ovf,
    input  logic             ev_rx_done,
    input  logic             ev_tx_done,
    input  logic             ev_tx_udf,
    input  logic             rdy_pin,
    input  logic             miso_pin,
    input  logic [1:0]       flow_mode,
    input  logic             flow_rise,
    input  logic             ctl_en,
    input  logic             ctl_tim,
    input  logic             ctl_rxovf_mask,
    input  logic             ctl_txudf_mask,
    input  logic             ie_rdy,
    input  logic             ie_cs,
    input  logic             ie_rxovf,
    input  logic             ie_txudf,
    output logic             irq
);

    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_clr;
    logic [NFLAG-1:0] flag_kill;
    logic [NFLAG-1:0] flag_q;
    logic             rdy_edge;
    logic             cs_lvl;
    logic             unused_wbits;

    assign unused_wbits = ^{reg_wdata[10:8], reg_wdata[CS_POS], reg_wdata[3:0]};

    spi_stat_rdy_edge u_rdy_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .rdy_pin_i  (rdy_pin),
        .miso_pin_i (miso_pin),
        .mode_i     (flow_mode),
        .rise_i     (flow_rise),
        .edge_o     (rdy_edge)
    );

    spi_stat_cs_sync #(.STAGES(SYNC_STAGES)) u_cs_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_i   (cs_n_raw),
        .cs_lvl_o (cs_lvl)
    );

    always_comb begin
        flag_set           = '0;
        flag_set[F_TXUDF]  = ev_tx_udf;
        flag_set[F_TXDONE] = ev_tx_done & ctl_tim;
        flag_set[F_RXDONE] = ev_rx_done & ~ctl_tim;
        flag_set[F_RXOVF]  = ev_rx_ovf;
        flag_set[F_CSERR]  = ev_cs_err;
        flag_set[F_CSRISE] = ev_cs_rise;
        flag_set[F_CSFALL] = ev_cs_fall;
        flag_set[F_RDY]    = rdy_edge;
    end

    generate
        for (genvar i = 0; i < NFLAG; i++) begin : g_flag
            assign flag_clr[i]  = reg_wr & reg_wdata[FLAG_POS[i]];
            assign flag_kill[i] = EN_KILL_MASK[i] & ~ctl_en;

            spi_stat_flag u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (flag_set[i]),
                .clr_i  (flag_clr[i]),
                .kill_i (flag_kill[i]),
                .q_o    (flag_q[i])
            );
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NFLAG; i++) reg_rdata[FLAG_POS[i]] = flag_q[i];
        reg_rdata[CS_POS] = cs_lvl;
    end

    spi_stat_irq_merge u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .flags_i      (flag_q),
        .ie_rdy_i     (ie_rdy),
        .ie_cs_i      (ie_cs),
        .ie_rxovf_i   (ie_rxovf),
        .ie_txudf_i   (ie_txudf),
        .rxovf_mask_i (ctl_rxovf_mask),
        .txudf_mask_i (ctl_txudf_mask),
        .irq_o        (irq)
    );

    assert_rx_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_tim && !reg_rdata[6]) |=> !reg_rdata[6]);

    assert_tx_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_tim && !reg_rdata[5]) |=> !reg_rdata[5]);

    assert_fall_survives_disable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[14] && !reg_wr) |=> reg_rdata[14]);

    assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[10:8] == 3'b000) && (reg_rdata[3:0] == 4'b0000));

endmodule

// File: tb/test_spi_stat_reg.sv
`timescale 1ns/1ps
module test_spi_stat_reg;

    localparam int SYNC = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, reg_wr;
    logic [15:0] reg_wdata, reg_rdata;
    logic        cs_n_raw, ev_cs_fall, ev_cs_rise, ev_cs_err, ev_rx_ovf;
    logic        ev_rx_done, ev_tx_done, ev_tx_udf, rdy_pin, miso_pin;
    logic [1:0]  flow_mode;
    logic        flow_rise, ctl_en, ctl_tim, ctl_rxovf_mask, ctl_txudf_mask;
    logic        ie_rdy, ie_cs, ie_rxovf, ie_txudf, irq;

    spi_stat_reg #(.SYNC_STAGES(SYNC)) i_spi_stat_reg (.*);

    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;
    logic [7:0]  ef;
    logic [SYNC-1:0] ecs;
    logic        ep_rdy, ep_miso;

    // Flag vector order: 7 rdy,6 fall,5 rise,4 err,3 rxovf,2 rxdone,1 txdone,0 txudf
    function automatic logic [15:0] pack(input logic [7:0] f, input logic c);
        return {f[7:4], c, 3'b000, f[3:0], 4'b0000};
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick(input string tag);
        logic line, prev, edg, eirq;
        logic [7:0] s, c, k, nf;
        line = flow_mode[0] ? miso_pin : rdy_pin;
        prev = flow_mode[0] ? ep_miso  : ep_rdy;
        edg  = flow_mode[1] & (flow_rise ? (line & ~prev) : (~line & prev));
        s = {edg, ev_cs_fall, ev_cs_rise, ev_cs_err, ev_rx_ovf,
             ev_rx_done & ~ctl_tim, ev_tx_done & ctl_tim, ev_tx_udf};
        c = reg_wr ? {reg_wdata[15:12], reg_wdata[7:4]} : 8'h00;
        k = ctl_en ? 8'h00 : 8'b0010_1111;
        nf = ((ef & ~c) | s) & ~k;
        eirq = (ef[7] & ie_rdy) | ((ef[6] | ef[5]) & ie_cs) | ef[4] |
               (ef[3] & ie_rxovf & ~ctl_rxovf_mask) | ef[2] | ef[1] |
               (ef[0] & ie_txudf & ~ctl_txudf_mask);
        @(posedge clk);
        ef      = nf;
        ecs     = {ecs[SYNC-2:0], cs_n_raw};
        ep_rdy  = rdy_pin;
        ep_miso = miso_pin;
        @(negedge clk);
        check({tag, " status"}, reg_rdata, pack(ef, ecs[SYNC-1]));
        check("R8 irq", {15'd0, irq}, {15'd0, eirq});
    endtask

    task automatic quiet();
        reg_wr = 0; reg_wdata = 0;
        ev_cs_fall = 0; ev_cs_rise = 0; ev_cs_err = 0; ev_rx_ovf = 0;
        ev_rx_done = 0; ev_tx_done = 0; ev_tx_udf = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240917));
        quiet();
        rst_n = 0; cs_n_raw = 1; rdy_pin = 0; miso_pin = 0;
        flow_mode = 2'b00; flow_rise = 1; ctl_en = 1; ctl_tim = 0;
        ctl_rxovf_mask = 0; ctl_txudf_mask = 0;
        ie_rdy = 1; ie_cs = 1; ie_rxovf = 1; ie_txudf = 1;
        repeat (3) @(negedge clk);
        check("R1 reset value", reg_rdata, 16'h0800);
        check("R1 reset irq", {15'd0, irq}, 16'd0);
        rst_n = 1;
        ef = 8'h00; ecs = '1; ep_rdy = 0; ep_miso = 0;
        tick("R1 after reset");

        // R3: set wins over same-cycle clear
        ev_cs_err = 1; reg_wr = 1; reg_wdata = 16'h1000;
        tick("R3 set wins");
        check("R3 err bit held", {15'd0, reg_rdata[12]}, 16'd1);
        quiet(); tick("R8 cserr irq");
        reg_wr = 1; reg_wdata = 16'h1000; tick("R3 clear");
        quiet();
        // R4: writes of all ones leave bit 11 and reserved bits unchanged
        reg_wr = 1; reg_wdata = 16'hFFFF; tick("R4 write ignored");
        check("R4 level bit", reg_rdata, 16'h0800);
        quiet();
        // R6: idle mode ignores ready edges
        rdy_pin = 1; tick("R6 idle mode");
        rdy_pin = 0; tick("R6 idle mode");
        flow_mode = 2'b10; rdy_pin = 1; tick("R6 ready rise");
        check("R6 rdy bit", {15'd0, reg_rdata[15]}, 16'd1);
        // R5: disable holds killable flags clear
        ctl_en = 0; ev_rx_ovf = 1; ev_cs_fall = 1; tick("R5 disabled");
        check("R5 ovf held", {14'd0, reg_rdata[7], reg_rdata[14]}, 16'd1);
        quiet(); ctl_en = 1;
        // R7: done gating by transfer mode
        ctl_tim = 1; ev_rx_done = 1; ev_tx_done = 1; tick("R7 tim set");
        check("R7 tx only", {14'd0, reg_rdata[6:5]}, 16'd1);
        quiet();
        cs_n_raw = 0; tick("R4 cs level");

        for (int n = 0; n < 4000; n++) begin
            reg_wr     = ($urandom % 4) == 0;
            reg_wdata  = 16'($urandom);
            ev_cs_fall = ($urandom % 7) == 0;
            ev_cs_rise = ($urandom % 7) == 0;
            ev_cs_err  = ($urandom % 9) == 0;
            ev_rx_ovf  = ($urandom % 7) == 0;
            ev_rx_done = ($urandom % 6) == 0;
            ev_tx_done = ($urandom % 6) == 0;
            ev_tx_udf  = ($urandom % 7) == 0;
            if (($urandom % 4) == 0) rdy_pin  = ~rdy_pin;
            if (($urandom % 4) == 0) miso_pin = ~miso_pin;
            if (($urandom % 6) == 0) cs_n_raw = ~cs_n_raw;
            if (($urandom % 16) == 0) begin
                flow_mode = 2'($urandom); flow_rise = 1'($urandom);
                ctl_en = ($urandom % 5) != 0; ctl_tim = 1'($urandom);
                ctl_rxovf_mask = 1'($urandom); ctl_txudf_mask = 1'($urandom);
                ie_rdy = 1'($urandom); ie_cs = 1'($urandom);
                ie_rxovf = 1'($urandom); ie_txudf = 1'($urandom);
            end
            tick("R2 R3 R5 R6 R7 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule